// File: doc/BRIEF.md
# Size-Aware Register File

This block is the architectural register store of a 32-bit processor core. It holds eight data registers and seven general address registers. The eighth address slot is the stack pointer, kept as two physical copies: one for user mode and one for supervisor mode. The privilege input picks which copy is reached. There are two combinational read ports and one write port that takes effect at the rising clock edge.

Each write carries an operand size and a class bit that selects data or address registers. The size and the class together decide how the stored word changes:

- Data registers merge a short operand into the low bits and keep the upper bits.
- Address registers always take a full 32-bit value. A 16-bit source is sign-extended first.
- A byte-sized write aimed at an address register is refused and flagged.

Reads also take a size. A short read returns only the low bits of the register, with the upper bits of the port cleared.

Top module: `cpu_regfile`

## Requirements
- R1: Register index 0 to 7 selects D0 to D7 when the class bit is 0. Index 0 to 6 selects A0 to A6 when the class bit is 1. Each of these fifteen registers stores its own 32-bit value independently of the others.
- R2: Address index 7 is the stack pointer. With priv_sup=1, reads and writes of index 7 reach the supervisor copy. With priv_sup=0, they reach the user copy. A write to one copy leaves the other copy unchanged.
- R3: Size code 2'b00 is byte. A byte write to a data register replaces bits 7:0 and keeps bits 31:8.
- R4: Size code 2'b01 is word. A word write to a data register replaces bits 15:0 and keeps bits 31:16.
- R5: Size code 2'b10 is long, and code 2'b11 behaves as long. A long write to a data register replaces all 32 bits.
- R6: A byte-size write with the class bit set raises wr_reject in the same cycle and changes no register. wr_reject is low for every other write and whenever wr_en is low.
- R7: A word write to an address register stores bit 15 of the source copied into bits 31:16, and the source bits 15:0 into bits 15:0.
- R8: A long write to an address register replaces all 32 bits.
- R9: Read data depends on the class bit and the size, as follows:
  - Data register, byte size: bits 7:0 of the register, with zeros above.
  - Data register, word size: bits 15:0, with zeros above.
  - Data register, long size: the full register.
  - Address register, long size: the full register.
  - Address register, byte or word size: bits 15:0, with zeros above.
- R10: A read of the register being written in the same cycle returns the value from before the write. The new value is visible after the rising edge.
- R11: A synchronous active-high reset clears all data registers, all address registers and both stack pointer copies to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| priv_sup | input | 1 | 1 = supervisor mode, 0 = user mode; selects the stack pointer copy |
| wr_en | input | 1 | Write request |
| wr_is_addr | input | 1 | 1 = address register target, 0 = data register target |
| wr_idx | input | 3 | Write register index |
| wr_size | input | 2 | Write operand size: 00 byte, 01 word, 10/11 long |
| wr_data | input | 32 | Write source operand |
| wr_reject | output | 1 | Current write refused (byte write to an address register) |
| rd0_is_addr | input | 1 | Read port 0 class |
| rd0_idx | input | 3 | Read port 0 index |
| rd0_size | input | 2 | Read port 0 size |
| rd0_data | output | 32 | Read port 0 data |
| rd1_is_addr | input | 1 | Read port 1 class |
| rd1_idx | input | 3 | Read port 1 index |
| rd1_size | input | 2 | Read port 1 size |
| rd1_data | output | 32 | Read port 1 data |

## Verification
The bench builds the block with its default parameters: eight data registers and seven general address registers plus the two stack pointer copies. This is the full index space of the 3-bit selectors, so every slot, including both banked copies, can be written and read back. A reference model in the bench applies the merge, sign-extension and refusal rules. A scoreboard queue compares both read ports against that model after byte, word and long writes. It also checks the same-cycle read of the register being written and the clearing done by a reset issued in the middle of the run.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    parameter int unsigned XLEN  = 32;
    parameter int unsigned IDX_W = 3;
    localparam int unsigned HALF_W = XLEN / 2;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } opsize_e;

    typedef struct packed {
        logic             en;
        logic             is_addr;
        logic [IDX_W-1:0] idx;
        opsize_e          size;
        logic [XLEN-1:0]  data;
    } wr_req_t;

    // Merge a short operand into the old contents of a data register.
    function automatic logic [XLEN-1:0] merge_data(
        input logic [XLEN-1:0] old_v,
        input logic [XLEN-1:0] src,
        input opsize_e         sz
    );
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = {old_v[XLEN-1:BYTE_W], src[BYTE_W-1:0]};
            SZ_WORD: r = {old_v[XLEN-1:HALF_W], src[HALF_W-1:0]};
            default: r = src;
        endcase
        return r;
    endfunction

    // Widen a source for an address register: word sources sign-extend.
    function automatic logic [XLEN-1:0] widen_addr(
        input logic [XLEN-1:0] src,
        input opsize_e         sz
    );
        logic [XLEN-1:0] r;
        if (sz == SZ_WORD)
            r = {{(XLEN-HALF_W){src[HALF_W-1]}}, src[HALF_W-1:0]};
        else
            r = src;
        return r;
    endfunction

    // Shape a stored value for a read port according to class and size.
    function automatic logic [XLEN-1:0] shape_read(
        input logic [XLEN-1:0] v,
        input opsize_e         sz,
        input logic            is_addr
    );
        logic [XLEN-1:0] r;
        r = v;
        if (is_addr) begin
            if (sz == SZ_BYTE || sz == SZ_WORD)
                r = {{(XLEN-HALF_W){1'b0}}, v[HALF_W-1:0]};
        end else begin
            case (sz)
                SZ_BYTE: r = {{(XLEN-BYTE_W){1'b0}}, v[BYTE_W-1:0]};
                SZ_WORD: r = {{(XLEN-HALF_W){1'b0}}, v[HALF_W-1:0]};
                default: r = v;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/rf_data_bank.sv
module rf_data_bank
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  req,
    output logic [NUM_REGS*XLEN-1:0] regs_flat
);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_dreg
            logic [XLEN-1:0] q;
            logic            hit;

            assign hit = req.en && !req.is_addr && (req.idx == IDX_W'(i));

            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (hit)
                    q <= merge_data(q, req.data, req.size);
            end

            assign regs_flat[i*XLEN +: XLEN] = q;
        end
    endgenerate

endmodule

// File: rtl/rf_addr_bank.sv
module rf_addr_bank
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_GP = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   priv_sup,
    input  wr_req_t                req,
    output logic [NUM_GP*XLEN-1:0] gp_flat,
    output logic [XLEN-1:0]        usp_q,
    output logic [XLEN-1:0]        ssp_q,
    output logic                   reject
);

    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(NUM_GP);

    logic            accept;
    logic [XLEN-1:0] wide_v;
    logic            sp_hit;

    assign reject = req.en && req.is_addr && (req.size == SZ_BYTE);
    assign accept = req.en && req.is_addr && (req.size != SZ_BYTE);
    assign wide_v = widen_addr(req.data, req.size);
    assign sp_hit = accept && (req.idx == SP_IDX);

    generate
        for (genvar i = 0; i < NUM_GP; i++) begin : g_areg
            logic [XLEN-1:0] q;

            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (accept && (req.idx == IDX_W'(i)))
                    q <= wide_v;
            end

            assign gp_flat[i*XLEN +: XLEN] = q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            usp_q <= '0;
            ssp_q <= '0;
        end else if (sp_hit) begin
            if (priv_sup)
                ssp_q <= wide_v;
            else
                usp_q <= wide_v;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_D  = 8,
    parameter int unsigned NUM_GP = 7
) (
    input  logic [NUM_D*XLEN-1:0]  d_flat,
    input  logic [NUM_GP*XLEN-1:0] a_flat,
    input  logic [XLEN-1:0]        usp_q,
    input  logic [XLEN-1:0]        ssp_q,
    input  logic                   priv_sup,
    input  logic                   is_addr,
    input  logic [IDX_W-1:0]       idx,
    input  opsize_e                size,
    output logic [XLEN-1:0]        data
);

    logic [XLEN-1:0] d_sel;
    logic [XLEN-1:0] a_sel;

    always_comb begin
        d_sel = '0;
        for (int i = 0; i < NUM_D; i++) begin
            if (idx == IDX_W'(i))
                d_sel = d_flat[i*XLEN +: XLEN];
        end
    end

    always_comb begin
        a_sel = priv_sup ? ssp_q : usp_q;
        for (int i = 0; i < NUM_GP; i++) begin
            if (idx == IDX_W'(i))
                a_sel = a_flat[i*XLEN +: XLEN];
        end
    end

    assign data = shape_read(is_addr ? a_sel : d_sel, size, is_addr);

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_D  = 8,
    parameter int unsigned NUM_GP = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        priv_sup,
    input  logic        wr_en,
    input  logic        wr_is_addr,
    input  logic [2:0]  wr_idx,
    input  logic [1:0]  wr_size,
    input  logic [31:0] wr_data,
    output logic        wr_reject,
    input  logic        rd0_is_addr,
    input  logic [2:0]  rd0_idx,
    input  logic [1:0]  rd0_size,
    output logic [31:0] rd0_data,
    input  logic        rd1_is_addr,
    input  logic [2:0]  rd1_idx,
    input  logic [1:0]  rd1_size,
    output logic [31:0] rd1_data
);

    localparam int unsigned NUM_RD = 2;

    wr_req_t                  req;
    logic [NUM_D*XLEN-1:0]    d_flat;
    logic [NUM_GP*XLEN-1:0]   a_flat;
    logic [XLEN-1:0]          usp_q;
    logic [XLEN-1:0]          ssp_q;

    logic             rp_is_addr [NUM_RD];
    logic [IDX_W-1:0] rp_idx     [NUM_RD];
    opsize_e          rp_size    [NUM_RD];
    logic [XLEN-1:0]  rp_data    [NUM_RD];

    assign req.en      = wr_en;
    assign req.is_addr = wr_is_addr;
    assign req.idx     = wr_idx;
    assign req.size    = opsize_e'(wr_size);
    assign req.data    = wr_data;

    rf_data_bank #(.NUM_REGS(NUM_D)) u_dbank (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .regs_flat (d_flat)
    );

    rf_addr_bank #(.NUM_GP(NUM_GP)) u_abank (
        .clk      (clk),
        .rst      (rst),
        .priv_sup (priv_sup),
        .req      (req),
        .gp_flat  (a_flat),
        .usp_q    (usp_q),
        .ssp_q    (ssp_q),
        .reject   (wr_reject)
    );

    assign rp_is_addr[0] = rd0_is_addr;
    assign rp_idx[0]     = rd0_idx;
    assign rp_size[0]    = opsize_e'(rd0_size);
    assign rp_is_addr[1] = rd1_is_addr;
    assign rp_idx[1]     = rd1_idx;
    assign rp_size[1]    = opsize_e'(rd1_size);

    generate
        for (genvar p = 0; p < NUM_RD; p++) begin : g_rport
            rf_read_port #(.NUM_D(NUM_D), .NUM_GP(NUM_GP)) u_rp (
                .d_flat   (d_flat),
                .a_flat   (a_flat),
                .usp_q    (usp_q),
                .ssp_q    (ssp_q),
                .priv_sup (priv_sup),
                .is_addr  (rp_is_addr[p]),
                .idx      (rp_idx[p]),
                .size     (rp_size[p]),
                .data     (rp_data[p])
            );
        end
    endgenerate

    assign rd0_data = rp_data[0];
    assign rd1_data = rp_data[1];

endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_D  = 8,
    parameter int unsigned NUM_GP = 7
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   priv_sup,
    input logic                   wr_en,
    input logic                   wr_is_addr,
    input logic [2:0]             wr_idx,
    input logic [1:0]             wr_size,
    input logic [31:0]            wr_data,
    input logic                   wr_reject,
    input logic                   rd0_is_addr,
    input logic [1:0]             rd0_size,
    input logic [31:0]            rd0_data,
    input logic [NUM_D*XLEN-1:0]  d_flat,
    input logic [NUM_GP*XLEN-1:0] a_flat,
    input logic [XLEN-1:0]        usp_q,
    input logic [XLEN-1:0]        ssp_q
);

    logic [XLEN-1:0] d_now, d_prev_sel, d_old;
    logic [XLEN-1:0] a_prev_sel;
    logic [2:0]      p_idx;
    logic [31:0]     p_data;

    always_comb begin
        d_now = '0;
        for (int i = 0; i < NUM_D; i++)
            if (wr_idx == 3'(i)) d_now = d_flat[i*XLEN +: XLEN];
    end

    always_comb begin
        d_prev_sel = '0;
        a_prev_sel = '0;
        for (int i = 0; i < NUM_D; i++)
            if (p_idx == 3'(i)) d_prev_sel = d_flat[i*XLEN +: XLEN];
        for (int i = 0; i < NUM_GP; i++)
            if (p_idx == 3'(i)) a_prev_sel = a_flat[i*XLEN +: XLEN];
    end

    always_ff @(posedge clk) begin
        p_idx  <= wr_idx;
        p_data <= wr_data;
        d_old  <= d_now;
    end

    // R3
    a_r3_byte_merge: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_is_addr && wr_size == 2'b00)
        |=> d_prev_sel == {d_old[31:8], p_data[7:0]});

    // R4
    a_r4_word_merge: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_is_addr && wr_size == 2'b01)
        |=> d_prev_sel == {d_old[31:16], p_data[15:0]});

    // R6
    a_r6_reject_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_size == 2'b00) |-> wr_reject);

    a_r6_no_false_reject: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_is_addr && wr_size == 2'b00) |-> !wr_reject);

    a_r6_reject_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_size == 2'b00)
        |=> ($stable(a_flat) && $stable(usp_q) && $stable(ssp_q)));

    // R7
    a_r7_sign_extend: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_size == 2'b01 && wr_idx != 3'(NUM_GP))
        |=> a_prev_sel == {{16{p_data[15]}}, p_data[15:0]});

    // R2
    a_r2_user_spares_ssp: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_idx == 3'(NUM_GP) && !priv_sup) |=> $stable(ssp_q));

    a_r2_sup_spares_usp: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_addr && wr_idx == 3'(NUM_GP) && priv_sup) |=> $stable(usp_q));

    // R9
    a_r9_byte_read_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (!rd0_is_addr && rd0_size == 2'b00) |-> rd0_data[31:8] == 24'h0);

    // R11
    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (d_flat == '0 && a_flat == '0 && usp_q == '0 && ssp_q == '0));

endmodule

bind cpu_regfile cpu_regfile_chk #(.NUM_D(NUM_D), .NUM_GP(NUM_GP)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .priv_sup    (priv_sup),
    .wr_en       (wr_en),
    .wr_is_addr  (wr_is_addr),
    .wr_idx      (wr_idx),
    .wr_size     (wr_size),
    .wr_data     (wr_data),
    .wr_reject   (wr_reject),
    .rd0_is_addr (rd0_is_addr),
    .rd0_size    (rd0_size),
    .rd0_data    (rd0_data),
    .d_flat      (d_flat),
    .a_flat      (a_flat),
    .usp_q       (usp_q),
    .ssp_q       (ssp_q)
);

// File: tb/cpu_regfile_tb_top.sv
module cpu_regfile_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv_sup = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_is_addr = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_size = '0;
    logic [31:0] wr_data = '0;
    logic        wr_reject;
    logic        rd0_is_addr = 1'b0;
    logic [2:0]  rd0_idx = '0;
    logic [1:0]  rd0_size = 2'b10;
    logic [31:0] rd0_data;
    logic        rd1_is_addr = 1'b0;
    logic [2:0]  rd1_idx = '0;
    logic [1:0]  rd1_size = 2'b10;
    logic [31:0] rd1_data;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  go;

    logic [31:0] m_d [8];
    logic [31:0] m_a [7];
    logic [31:0] m_usp, m_ssp;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_regfile dut_i (
        .clk(clk), .rst(rst), .priv_sup(priv_sup),
        .wr_en(wr_en), .wr_is_addr(wr_is_addr), .wr_idx(wr_idx),
        .wr_size(wr_size), .wr_data(wr_data), .wr_reject(wr_reject),
        .rd0_is_addr(rd0_is_addr), .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
        .rd1_is_addr(rd1_is_addr), .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data)
    );

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endfunction

    // Monitor: pops expected items and compares against the read ports.
    initial begin
        forever begin
            @(go);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = (it.port == 0) ? rd0_data : rd1_data;
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s port%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    function automatic logic [31:0] model_read(logic is_a, logic [2:0] idx, logic [1:0] sz);
        logic [31:0] v;
        if (is_a) v = (idx == 3'd7) ? (priv_sup ? m_ssp : m_usp) : m_a[idx];
        else      v = m_d[idx];
        if (is_a) begin
            if (sz == 2'b00 || sz == 2'b01) v = {16'h0, v[15:0]};
        end else begin
            if (sz == 2'b00)      v = {24'h0, v[7:0]};
            else if (sz == 2'b01) v = {16'h0, v[15:0]};
        end
        return v;
    endfunction

    task automatic drive_read(int port, logic is_a, logic [2:0] idx, logic [1:0] sz);
        if (port == 0) begin
            rd0_is_addr = is_a; rd0_idx = idx; rd0_size = sz;
        end else begin
            rd1_is_addr = is_a; rd1_idx = idx; rd1_size = sz;
        end
    endtask

    task automatic push_and_go(int port, logic [31:0] exp, string tag);
        item_t it;
        it.port = port; it.exp = exp; it.tag = tag;
        #1;
        sb_q.push_back(it);
        ->go;
        #1;
    endtask

    // Read with a literal expected value (called in the low clock phase).
    task automatic rd_lit(int port, logic is_a, logic [2:0] idx, logic [1:0] sz,
                          logic [31:0] exp, string tag);
        drive_read(port, is_a, idx, sz);
        push_and_go(port, exp, tag);
    endtask

    // Read with an expected value from the bench model.
    task automatic rd_mod(int port, logic is_a, logic [2:0] idx, logic [1:0] sz, string tag);
        drive_read(port, is_a, idx, sz);
        push_and_go(port, model_read(is_a, idx, sz), tag);
    endtask

    task automatic model_write(logic is_a, logic [2:0] idx, logic [1:0] sz, logic [31:0] v);
        logic [31:0] w;
        if (is_a) begin
            if (sz != 2'b00) begin
                w = (sz == 2'b01) ? {{16{v[15]}}, v[15:0]} : v;
                if (idx == 3'd7) begin
                    if (priv_sup) m_ssp = w; else m_usp = w;
                end else m_a[idx] = w;
            end
        end else begin
            if (sz == 2'b00)      m_d[idx] = {m_d[idx][31:8], v[7:0]};
            else if (sz == 2'b01) m_d[idx] = {m_d[idx][31:16], v[15:0]};
            else                  m_d[idx] = v;
        end
    endtask

    // Write, checking the reject flag in the same cycle; returns in the low phase.
    task automatic wr(logic is_a, logic [2:0] idx, logic [1:0] sz, logic [31:0] v, string tag);
        logic exp_rej;
        @(negedge clk);
        wr_en = 1'b1; wr_is_addr = is_a; wr_idx = idx; wr_size = sz; wr_data = v;
        exp_rej = is_a && (sz == 2'b00);
        #1;
        checks++;
        if (wr_reject !== exp_rej) begin
            fails++;
            $display("FAIL %s reject actual=%b expected=%b", tag, wr_reject, exp_rej);
        end
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(is_a, idx, sz, v);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) m_d[i] = '0;
        for (int i = 0; i < 7; i++) m_a[i] = '0;
        m_usp = '0;
        m_ssp = '0;
        @(negedge clk);
    endtask

    task automatic check_all_zero(string tag);
        for (int i = 0; i < 8; i++) rd_lit(0, 1'b0, 3'(i), 2'b10, 32'h0, tag);
        for (int i = 0; i < 8; i++) rd_lit(1, 1'b1, 3'(i), 2'b10, 32'h0, tag);
        priv_sup = ~priv_sup;
        rd_lit(1, 1'b1, 3'd7, 2'b10, 32'h0, tag);
        priv_sup = ~priv_sup;
    endtask

    initial begin
        do_reset();
        // R11: reset state
        check_all_zero("R11 reset state");

        // R5: long data write
        wr(1'b0, 3'd3, 2'b10, 32'h12345678, "R5 long write");
        rd_lit(0, 1'b0, 3'd3, 2'b10, 32'h12345678, "R5 long data");
        // R3: byte merge, R9 byte read
        wr(1'b0, 3'd3, 2'b00, 32'hFFFFFFAB, "R3 byte write");
        rd_lit(0, 1'b0, 3'd3, 2'b10, 32'h123456AB, "R3 byte merge keeps upper");
        rd_lit(1, 1'b0, 3'd3, 2'b00, 32'h000000AB, "R9 data byte read");
        // R4: word merge, R9 word read
        wr(1'b0, 3'd3, 2'b01, 32'h9999CDEF, "R4 word write");
        rd_lit(0, 1'b0, 3'd3, 2'b10, 32'h1234CDEF, "R4 word merge keeps upper");
        rd_lit(1, 1'b0, 3'd3, 2'b01, 32'h0000CDEF, "R9 data word read");
        // R5: reserved size code acts as long
        wr(1'b0, 3'd4, 2'b11, 32'hCAFEF00D, "R5 size 11 write");
        rd_lit(0, 1'b0, 3'd4, 2'b10, 32'hCAFEF00D, "R5 size 11 as long");

        // R7: sign extension, both signs
        wr(1'b1, 3'd2, 2'b01, 32'h00008001, "R7 word neg");
        rd_lit(0, 1'b1, 3'd2, 2'b10, 32'hFFFF8001, "R7 sign extend negative");
        wr(1'b1, 3'd2, 2'b01, 32'hFFFF7FFF, "R7 word pos");
        rd_lit(0, 1'b1, 3'd2, 2'b10, 32'h00007FFF, "R7 sign extend positive");
        // R8: long address write; R9 address word and byte read
        wr(1'b1, 3'd5, 2'b10, 32'hDEADBEEF, "R8 long addr");
        rd_lit(0, 1'b1, 3'd5, 2'b10, 32'hDEADBEEF, "R8 long addr full");
        rd_lit(1, 1'b1, 3'd5, 2'b01, 32'h0000BEEF, "R9 addr word read");
        rd_lit(1, 1'b1, 3'd5, 2'b00, 32'h0000BEEF, "R9 addr byte read");

        // R6: byte write to address register refused
        wr(1'b1, 3'd5, 2'b00, 32'h00000011, "R6 addr byte");
        rd_lit(0, 1'b1, 3'd5, 2'b10, 32'hDEADBEEF, "R6 rejected leaves reg");
        wr(1'b1, 3'd7, 2'b00, 32'h00000022, "R6 sp byte");
        rd_lit(0, 1'b1, 3'd7, 2'b10, 32'h0, "R6 rejected leaves sp");
        wr(1'b0, 3'd5, 2'b00, 32'h00000033, "R6 data byte not rejected");

        // R2: banked stack pointer
        priv_sup = 1'b0;
        wr(1'b1, 3'd7, 2'b10, 32'h00001000, "R2 user sp");
        priv_sup = 1'b1;
        wr(1'b1, 3'd7, 2'b10, 32'h00002000, "R2 sup sp");
        rd_lit(0, 1'b1, 3'd7, 2'b10, 32'h00002000, "R2 sup copy");
        priv_sup = 1'b0;
        rd_lit(0, 1'b1, 3'd7, 2'b10, 32'h00001000, "R2 user copy");
        wr(1'b1, 3'd7, 2'b01, 32'h00009000, "R2 user word sp");
        rd_lit(0, 1'b1, 3'd7, 2'b10, 32'hFFFF9000, "R2 user sp word sext");
        priv_sup = 1'b1;
        rd_lit(1, 1'b1, 3'd7, 2'b10, 32'h00002000, "R2 sup copy untouched");
        priv_sup = 1'b0;

        // R1: all slots independent
        for (int i = 0; i < 8; i++)
            wr(1'b0, 3'(i), 2'b10, 32'hD0000000 + 32'(i) * 32'h01010101, "R1 fill data");
        for (int i = 0; i < 7; i++)
            wr(1'b1, 3'(i), 2'b10, 32'hA0000000 + 32'(i) * 32'h00110011, "R1 fill addr");
        for (int i = 0; i < 8; i++) rd_mod(0, 1'b0, 3'(i), 2'b10, "R1 data slot");
        for (int i = 0; i < 8; i++) rd_mod(1, 1'b1, 3'(i), 2'b10, "R1 addr slot");

        // R10: same-cycle read returns old value
        @(negedge clk);
        wr_en = 1'b1; wr_is_addr = 1'b0; wr_idx = 3'd6; wr_size = 2'b10; wr_data = 32'hA5A5A5A5;
        drive_read(0, 1'b0, 3'd6, 2'b10);
        push_and_go(0, m_d[6], "R10 old value same cycle");
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(1'b0, 3'd6, 2'b10, 32'hA5A5A5A5);
        @(negedge clk);
        rd_lit(0, 1'b0, 3'd6, 2'b10, 32'hA5A5A5A5, "R10 new value after edge");

        // R11: reset mid-run clears everything, including supervisor copy
        priv_sup = 1'b1;
        wr(1'b1, 3'd7, 2'b10, 32'h0BADF00D, "R11 preload ssp");
        priv_sup = 1'b0;
        do_reset();
        check_all_zero("R11 reset clears");

        summary();
        $finish;
    end

endmodule